// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). It looks at the instruction words held in the decode, execute, memory and write-back pipe registers. From them it works out which registers each instruction reads and writes. It then drives the operand multiplexers of the execute stage and the store-data multiplexer of the memory stage, so that results reach their consumers before they are written to the register file.

The one dependence that forwarding cannot cover is a load whose result is needed by the very next instruction's ALU operand or address base. In that case the block freezes fetch and decode for one cycle and feeds a bubble into execute. A store that only needs the loaded value as its data is not frozen: the loaded word is passed from write-back into the store's data input while the store is in the memory stage.

The block is purely combinational. Each pipe register receives a three-way control from it: load the next state, hold the current state, or clear to zero. An all-zero instruction word acts as a no-op.

Top module: `hz_unit`

## Requirements
- R1: Opcode is bits [31:26]. Operand A is bits [25:21], operand B is bits [20:16], and the ALU destination is bits [4:0]. Opcodes 0x10..0x13 are ALU operations: they read A, read B unless literal, and write the destination. Opcode 0x29 is a load: it reads B and writes A. Opcode 0x2D is a store: it reads A and B. Opcodes 0x38..0x3F are conditional branches: they read A. Opcode 0x1A is a jump: it reads B. A field that the class does not read or write never produces a match.
- R2: Register 31 is never treated as written. No forwarding select and no interlock is ever raised for it.
- R3: `alu_a_sel` and `alu_b_sel` take the value 1 when the execute instruction reads that operand and the memory-stage instruction is a non-load that writes the same register.
- R4: A select takes the value 2 when the write-back instruction writes the operand register and R3 does not apply. Otherwise the select is 0, meaning the register-file value.
- R5: When both the memory-stage and the write-back-stage instructions write the operand register, the select is 1 (the younger result).
- R6: An ALU instruction with bit 12 set carries an 8-bit literal in bits [20:13]. Its B select stays 0 whatever bits [20:16] hold.
- R7: A load in the memory stage never drives a select of 1. Its data is not ready until the end of that stage.
- R8: `st_data_sel` is 1 exactly when the memory-stage instruction is a store, the write-back instruction is a load, and the load's destination equals the store's operand A. Otherwise it is 0.
- R9: When a load in execute writes a register that the decode instruction reads (operand A of an ALU op or branch; operand B of an ALU op, load, store or jump), the controls are: fetch = 1 (hold), decode = 1 (hold), execute = 2 (clear), memory = 0 and write-back = 0 (load).
- R10: A store in decode whose operand A alone matches a load in execute raises no interlock.
- R11: An all-zero instruction word reads and writes nothing. With all four words zero, every output is 0.
- R12: Without a load-use dependence, all five pipe-register controls are 0 (load).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_instr | input | 32 | Instruction word in the decode pipe register |
| ex_instr | input | 32 | Instruction word in the execute pipe register |
| mem_instr | input | 32 | Instruction word in the memory pipe register |
| wb_instr | input | 32 | Instruction word in the write-back pipe register |
| alu_a_sel | output | 2 | Operand A source: 0 register file, 1 memory-stage result, 2 write-back result |
| alu_b_sel | output | 2 | Operand B source, same encoding as operand A |
| st_data_sel | output | 1 | 1: store data taken from write-back load data |
| if_ctl | output | 2 | Program-counter register control: 0 load, 1 hold, 2 clear |
| id_ctl | output | 2 | Fetch/decode register control |
| ex_ctl | output | 2 | Decode/execute register control |
| mem_ctl | output | 2 | Execute/memory register control |
| wb_ctl | output | 2 | Memory/write-back register control |

## Verification
The bench uses the default 5-bit register index and 32-bit word. It draws every register field from the set {0, 7, 31}, so that plain matches, the always-zero register 31 and the fields of a zero word are all hit. Each of the seven instruction classes (register ALU, literal ALU, load, store, branch, jump, zero word) is swept through every pipe slot. This covers every writer/reader/distance combination, the priority case in which both later stages match, and every load-use pairing, each against a value model written from the requirements.

// File: rtl/hz_pkg.sv
// Shared types and encodings for the hazard unit.
// Assumes a 32-bit fixed instruction format with 5-bit register fields.
package hz_pkg;
    localparam int INSTR_W  = 32;
    localparam int REG_AW   = 5;
    localparam int OPC_W    = 6;
    localparam int OPC_LSB  = INSTR_W - OPC_W;
    localparam int RA_LSB   = 21;
    localparam int RB_LSB   = 16;
    localparam int RC_LSB   = 0;
    localparam int LIT_BIT  = 12;
    localparam int NUM_OPND = 2;
    localparam int NUM_PREG = 5;
    localparam int NUM_STG  = 4;

    typedef logic [REG_AW-1:0] reg_idx_t;
    localparam reg_idx_t ZERO_REG = '1;

    localparam logic [OPC_W-1:0] OPC_LOAD    = 6'h29;
    localparam logic [OPC_W-1:0] OPC_STORE   = 6'h2D;
    localparam logic [OPC_W-1:0] OPC_JUMP    = 6'h1A;
    localparam logic [3:0]       OPC_ALU_TOP = 4'b0100;
    localparam logic [2:0]       OPC_BR_TOP  = 3'b111;

    typedef enum logic [1:0] {
        OPND_REG = 2'd0,
        OPND_MEM = 2'd1,
        OPND_WB  = 2'd2
    } opnd_sel_e;

    typedef enum logic [1:0] {
        PR_LOAD  = 2'd0,
        PR_HOLD  = 2'd1,
        PR_CLEAR = 2'd2
    } preg_ctl_e;

    typedef struct packed {
        logic     rd_a;
        logic     rd_b;
        reg_idx_t src_a;
        reg_idx_t src_b;
        logic     wr;
        reg_idx_t dst;
        logic     is_load;
        logic     is_store;
    } uop_info_t;
endpackage

// File: rtl/hz_decode.sv
// Classifies one instruction word: which register fields it reads, which it
// writes, and whether it is a load or a store. A write to the zero register
// is reported as no write, so later compare logic never matches it.
// Assumes an all-zero word is a no-op (opcode 0 is outside every class).
module hz_decode
    import hz_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output uop_info_t          info
);
    logic [OPC_W-1:0] opc;
    reg_idx_t         fld_a;
    reg_idx_t         fld_b;
    reg_idx_t         fld_c;
    logic             lit_form;
    logic             unused_bits;

    assign opc         = instr[OPC_LSB +: OPC_W];
    assign fld_a       = instr[RA_LSB +: REG_AW];
    assign fld_b       = instr[RB_LSB +: REG_AW];
    assign fld_c       = instr[RC_LSB +: REG_AW];
    assign lit_form    = instr[LIT_BIT];
    assign unused_bits = ^{instr[RB_LSB-1:LIT_BIT+1], instr[LIT_BIT-1:RC_LSB+REG_AW]};

    // Map opcode class to read/write usage of the register fields.
    always_comb begin
        info       = '0;
        info.src_a = fld_a;
        info.src_b = fld_b;
        if (opc[OPC_W-1 -: 4] == OPC_ALU_TOP) begin
            info.rd_a = 1'b1;
            info.rd_b = !lit_form;
            info.wr   = 1'b1;
            info.dst  = fld_c;
        end else if (opc == OPC_LOAD) begin
            info.rd_b    = 1'b1;
            info.wr      = 1'b1;
            info.dst     = fld_a;
            info.is_load = 1'b1;
        end else if (opc == OPC_STORE) begin
            info.rd_a     = 1'b1;
            info.rd_b     = 1'b1;
            info.is_store = 1'b1;
        end else if (opc[OPC_W-1 -: 3] == OPC_BR_TOP) begin
            info.rd_a = 1'b1;
        end else if (opc == OPC_JUMP) begin
            info.rd_b = 1'b1;
        end
        if (info.dst == ZERO_REG) begin
            info.wr = 1'b0;
        end
    end
endmodule

// File: rtl/hz_fwd.sv
// Forwarding select logic. For each execute-stage operand it picks the
// memory-stage result, the write-back result or the register file, with the
// younger result first. It also picks load data for a store's data input.
// Assumes a load in the memory stage has no result yet.
module hz_fwd
    import hz_pkg::*;
(
    input  uop_info_t                  ex_info,
    input  uop_info_t                  mem_info,
    input  uop_info_t                  wb_info,
    output logic [NUM_OPND-1:0][1:0]   opnd_sel,
    output logic                       st_from_wb
);
    logic unused_info;
    assign unused_info = ^{ex_info, mem_info, wb_info};

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
        logic     rd;
        reg_idx_t src;
        logic     hit_mem;
        logic     hit_wb;

        // Select which field and read flag this operand lane uses.
        assign rd  = (k == 0) ? ex_info.rd_a  : ex_info.rd_b;
        assign src = (k == 0) ? ex_info.src_a : ex_info.src_b;

        // Match against pending writes; loads in MEM are not yet usable.
        assign hit_mem = rd && mem_info.wr && !mem_info.is_load && (mem_info.dst == src);
        assign hit_wb  = rd && wb_info.wr && (wb_info.dst == src);

        // Younger producer wins.
        assign opnd_sel[k] = hit_mem ? OPND_MEM : (hit_wb ? OPND_WB : OPND_REG);
    end

    // Load in write-back feeding the data of a store in memory.
    assign st_from_wb = mem_info.is_store && wb_info.is_load && wb_info.wr &&
                        (wb_info.dst == mem_info.src_a);
endmodule

// File: rtl/hz_interlock.sv
// Load-use interlock and pipe-register control. When the decode instruction
// needs, as an ALU operand or address base, the register a load in execute
// is producing, every register ahead of execute holds, execute is cleared,
// and the rest load.
// Assumes store data is covered by the memory-to-memory path, not a stall.
module hz_interlock
    import hz_pkg::*;
#(
    parameter int PREGS   = NUM_PREG,
    parameter int EX_PREG = 2
) (
    input  uop_info_t               id_info,
    input  uop_info_t               ex_info,
    output logic                    load_use,
    output logic [PREGS-1:0][1:0]   preg_ctl
);
    logic hit_a;
    logic hit_b;
    logic unused_info;

    assign unused_info = ^{id_info, ex_info};

    // Operand A of a store is data, not address, so it never stalls.
    assign hit_a    = id_info.rd_a && !id_info.is_store && (id_info.src_a == ex_info.dst);
    assign hit_b    = id_info.rd_b && (id_info.src_b == ex_info.dst);
    assign load_use = ex_info.is_load && ex_info.wr && (hit_a || hit_b);

    for (genvar g = 0; g < PREGS; g++) begin : g_ctl
        if (g < EX_PREG) begin : g_front
            // Registers ahead of execute freeze on a load-use.
            assign preg_ctl[g] = load_use ? PR_HOLD : PR_LOAD;
        end else if (g == EX_PREG) begin : g_ex
            // Execute receives the bubble.
            assign preg_ctl[g] = load_use ? PR_CLEAR : PR_LOAD;
        end else begin : g_back
            // Older instructions drain normally.
            assign preg_ctl[g] = PR_LOAD;
        end
    end
endmodule

// File: rtl/hz_unit.sv
// Top of the hazard unit. Decodes the four held instruction words, drives
// operand and store-data selects, and issues pipe-register controls.
// Assumes the surrounding pipeline applies the controls at its next edge.
module hz_unit
    import hz_pkg::*;
(
    input  logic [31:0] id_instr,
    input  logic [31:0] ex_instr,
    input  logic [31:0] mem_instr,
    input  logic [31:0] wb_instr,
    output logic [1:0]  alu_a_sel,
    output logic [1:0]  alu_b_sel,
    output logic        st_data_sel,
    output logic [1:0]  if_ctl,
    output logic [1:0]  id_ctl,
    output logic [1:0]  ex_ctl,
    output logic [1:0]  mem_ctl,
    output logic [1:0]  wb_ctl
);
    localparam int S_ID  = 0;
    localparam int S_EX  = 1;
    localparam int S_MEM = 2;
    localparam int S_WB  = 3;

    logic [INSTR_W-1:0]           stage_word [NUM_STG];
    uop_info_t                    stage_info [NUM_STG];
    logic [NUM_OPND-1:0][1:0]     opnd_sel;
    logic [NUM_PREG-1:0][1:0]     preg_ctl;
    logic                         load_use;

    assign stage_word[S_ID]  = id_instr;
    assign stage_word[S_EX]  = ex_instr;
    assign stage_word[S_MEM] = mem_instr;
    assign stage_word[S_WB]  = wb_instr;

    for (genvar s = 0; s < NUM_STG; s++) begin : g_dec
        hz_decode u_dec (
            .instr (stage_word[s]),
            .info  (stage_info[s])
        );
    end

    hz_fwd u_fwd (
        .ex_info    (stage_info[S_EX]),
        .mem_info   (stage_info[S_MEM]),
        .wb_info    (stage_info[S_WB]),
        .opnd_sel   (opnd_sel),
        .st_from_wb (st_data_sel)
    );

    hz_interlock #(.PREGS(NUM_PREG), .EX_PREG(2)) u_lock (
        .id_info  (stage_info[S_ID]),
        .ex_info  (stage_info[S_EX]),
        .load_use (load_use),
        .preg_ctl (preg_ctl)
    );

    assign alu_a_sel = opnd_sel[0];
    assign alu_b_sel = opnd_sel[1];
    assign if_ctl    = preg_ctl[0];
    assign id_ctl    = preg_ctl[1];
    assign ex_ctl    = preg_ctl[2];
    assign mem_ctl   = preg_ctl[3];
    assign wb_ctl    = preg_ctl[4];

    // Cross-check selects and controls against the decoded stage contents.
    always_comb begin
        // R2: nothing forwarded for the zero register.
        p_no_zero_fwd_r2: assert ((alu_a_sel == OPND_REG) || (stage_info[S_EX].src_a != ZERO_REG))
            else $error("operand A forwarded for the zero register");
        // R7: a memory-stage select never comes from a load.
        p_mem_not_load_r7: assert (!((alu_a_sel == OPND_MEM) || (alu_b_sel == OPND_MEM)) ||
                                   !stage_info[S_MEM].is_load)
            else $error("load result forwarded from memory stage");
        // R3: encodings stay within the defined set.
        p_sel_legal_r3: assert ((alu_a_sel != 2'd3) && (alu_b_sel != 2'd3))
            else $error("illegal operand select");
        // R8: store data path only between a store and an older load.
        p_store_pair_r8: assert (!st_data_sel ||
                                 (stage_info[S_MEM].is_store && stage_info[S_WB].is_load))
            else $error("store data forward without load/store pair");
        // R9: a clear into execute comes with a frozen front end.
        p_stall_shape_r9: assert ((ex_ctl != PR_CLEAR) ||
                                  ((if_ctl == PR_HOLD) && (id_ctl == PR_HOLD) &&
                                   (mem_ctl == PR_LOAD) && (wb_ctl == PR_LOAD)))
            else $error("bubble without matching hold");
        // R9: an interlock needs a load in execute.
        p_stall_cause_r9: assert (!load_use || stage_info[S_EX].is_load)
            else $error("interlock without a load in execute");
    end
endmodule

// File: tb/hz_unit_test.sv
`timescale 1ns/1ps
module hz_unit_test;
    localparam int C_RR = 0, C_RI = 1, C_LD = 2, C_ST = 3, C_BR = 4, C_JMP = 5, C_NOP = 6;
    localparam int NCLS = 7;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] id_instr, ex_instr, mem_instr, wb_instr;
    logic [1:0]  alu_a_sel, alu_b_sel;
    logic        st_data_sel;
    logic [1:0]  if_ctl, id_ctl, ex_ctl, mem_ctl, wb_ctl;

    int n_checks = 0;
    int n_err    = 0;

    hz_unit uut (
        .id_instr(id_instr), .ex_instr(ex_instr), .mem_instr(mem_instr), .wb_instr(wb_instr),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .st_data_sel(st_data_sel),
        .if_ctl(if_ctl), .id_ctl(id_ctl), .ex_ctl(ex_ctl), .mem_ctl(mem_ctl), .wb_ctl(wb_ctl)
    );

    function automatic logic [4:0] pick(int i);
        return (i == 0) ? 5'd0 : (i == 1) ? 5'd7 : 5'd31;
    endfunction

    function automatic logic [31:0] mk(int c, logic [4:0] ra, logic [4:0] rb, logic [4:0] rc);
        case (c)
            C_RR:    return {6'h10, ra, rb, 3'b000, 1'b0, 7'h20, rc};
            C_RI:    return {6'h11, ra, rb, 3'b101, 1'b1, 7'h40, rc};
            C_LD:    return {6'h29, ra, rb, 16'h0008};
            C_ST:    return {6'h2D, ra, rb, 16'h0010};
            C_BR:    return {6'h39, ra, rb, 16'h0004};
            C_JMP:   return {6'h1A, ra, rb, 16'h0001};
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit rda(int c);
        return (c == C_RR) || (c == C_RI) || (c == C_ST) || (c == C_BR);
    endfunction
    function automatic bit rdb(int c);
        return (c == C_RR) || (c == C_LD) || (c == C_ST) || (c == C_JMP);
    endfunction
    function automatic bit wrs(int c);
        return (c == C_RR) || (c == C_RI) || (c == C_LD);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected select and requirement tag for one operand lane.
    task automatic lane(input bit rd, input bit lit, input int mc, input int wc,
                        input logic [4:0] mr, input logic [4:0] wr, input logic [4:0] src,
                        input int act);
        bit    mhit, whit;
        int    exp;
        string tag;
        mhit = wrs(mc) && (mr != 5'd31) && (mr == src);
        whit = wrs(wc) && (wr != 5'd31) && (wr == src);
        exp  = !rd ? 0 : (mhit && mc != C_LD) ? 1 : whit ? 2 : 0;
        if (lit)                              tag = "R6";
        else if (!rd)                         tag = "R1";
        else if (mhit && mc == C_LD)          tag = "R7";
        else if (exp == 1 && whit)            tag = "R5";
        else if (exp == 1)                    tag = "R3";
        else if (exp == 2)                    tag = "R4";
        else if (src == 5'd31)                tag = "R2";
        else if ((mc == C_NOP || wc == C_NOP) && src == 5'd0) tag = "R11";
        else                                  tag = "R12";
        chk(tag, act, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        id_instr = '0; ex_instr = '0; mem_instr = '0; wb_instr = '0;
        @(negedge clk);
        #1;
        // R11: idle state with all-zero words.
        chk("R11", alu_a_sel, 0);
        chk("R11", alu_b_sel, 0);
        chk("R11", st_data_sel, 0);
        chk("R11", {if_ctl, id_ctl, ex_ctl, mem_ctl, wb_ctl}, 0);

        // Forwarding sweep: every class in MEM, WB and EX slots.
        for (int mc = 0; mc < NCLS; mc++)
        for (int wc = 0; wc < NCLS; wc++)
        for (int ec = 0; ec < NCLS; ec++)
        for (int mi = 0; mi < 3; mi++)
        for (int wi = 0; wi < 3; wi++)
        for (int ai = 0; ai < 3; ai++)
        for (int bi = 0; bi < 3; bi++) begin
            logic [4:0] mr, wr, ea, eb;
            bit st_exp;
            mr = pick(mi); wr = pick(wi); ea = pick(ai); eb = pick(bi);
            @(negedge clk);
            id_instr  = '0;
            mem_instr = mk(mc, mr, 5'd1, mr);
            wb_instr  = mk(wc, wr, 5'd1, wr);
            ex_instr  = mk(ec, ea, eb, 5'd2);
            #1;
            lane(rda(ec), 1'b0, mc, wc, mr, wr, ea, alu_a_sel);
            lane(rdb(ec), ec == C_RI, mc, wc, mr, wr, eb, alu_b_sel);
            st_exp = (mc == C_ST) && (wc == C_LD) && (wr != 5'd31) && (wr == mr);
            chk("R8", st_data_sel, st_exp);
        end

        // Interlock sweep: every class in EX and ID slots.
        for (int ec = 0; ec < NCLS; ec++)
        for (int ic = 0; ic < NCLS; ic++)
        for (int di = 0; di < 3; di++)
        for (int ai = 0; ai < 3; ai++)
        for (int bi = 0; bi < 3; bi++) begin
            logic [4:0] ed, ia, ib;
            bit stall, st_only;
            string tag;
            ed = pick(di); ia = pick(ai); ib = pick(bi);
            @(negedge clk);
            mem_instr = '0;
            wb_instr  = '0;
            ex_instr  = mk(ec, ed, 5'd1, ed);
            id_instr  = mk(ic, ia, ib, 5'd3);
            #1;
            stall = (ec == C_LD) && (ed != 5'd31) &&
                    ((rda(ic) && ic != C_ST && ia == ed) || (rdb(ic) && ib == ed));
            st_only = (ec == C_LD) && (ed != 5'd31) && (ic == C_ST) && (ia == ed) && (ib != ed);
            if (stall)                             tag = "R9";
            else if (st_only)                      tag = "R10";
            else if (ec == C_LD && ed == 5'd31)    tag = "R2";
            else if (ec == C_LD)                   tag = "R1";
            else                                   tag = "R12";
            chk(tag, if_ctl,  stall ? 1 : 0);
            chk(tag, id_ctl,  stall ? 1 : 0);
            chk(tag, ex_ctl,  stall ? 2 : 0);
            chk(tag, mem_ctl, 0);
            chk(tag, wb_ctl,  0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule